// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block is a clause 22 MDIO management master that a host drives through a single 32-bit control/status word. One write to that word can start a management frame toward a PHY. The word carries the operation, the PHY number, the register number and the 16-bit payload. The host then polls the busy flag until it drops. When the frame was a read, the host takes the returned value from the low half of the same word.

The block also chooses who drives the PHY management pins. While the enable bit is clear, an external management bus reaches the PHYs through a pass-through path. While the enable bit is set, the internal sequencer owns the clock and data lines and the external path is cut off. MDC is made from the system clock by a divider with DIV_HALF system cycles per half period. MDC runs only while a frame is in flight.

Top module: `mdio_ctl_master`

## Requirements
- R1: A synchronous active-high reset makes the control word read as 0. This means not busy, enable clear and data 0. The internal MDC stays low and the internal data driver is released.
- R2: While enable (bit 30) is clear, phy_mdc, phy_mdio_out and phy_mdio_oe follow ext_mdc, ext_mdio_out and ext_mdio_oe. In this mode ext_mdio_in follows phy_mdio_in.
- R3: While enable is set, the external pins have no effect on the PHY pins and ext_mdio_in reads 1. When no frame is running, phy_mdc is low and phy_mdio_oe is 0.
- R4: A write accepted while idle with bit 31 (busy) and bit 30 (enable) both set starts a frame. Busy reads 1 from the next cycle for exactly 2*DIV_HALF cycles per frame bit, and then reads 0.
- R5: MDC has a period of 2*DIV_HALF system cycles. It is low for the first DIV_HALF cycles of each bit and high for the second DIV_HALF cycles. It idles low between frames.
- R6: A write frame (bit 27 = 0) is sent MSB first, with the line driven throughout. The bit order is: 32 ones, start 01, opcode 01, PHY address from bits 25:21, register address from bits 20:16, turnaround 10, then the 16 data bits from bits 15:0.
- R7: A read frame (bit 27 = 1) sends opcode 10. It releases the line (oe = 0) for the two turnaround bits and the 16 data bits. It samples each data bit on the rising MDC edge. At completion the sampled value appears in bits 15:0.
- R8: With bit 26 set, the 32-bit preamble is left out, so the frame is 32 bits long and busy lasts 64*DIV_HALF cycles.
- R9: A control write while busy reads 1 is ignored. The fields and the frame in flight are unchanged.
- R10: A read with no responding PHY (the line pulled high) returns 0xFFFF in bits 15:0.
- R11: A write with bit 30 clear starts no frame, even if bit 31 is set. Busy stays 0, and the other fields are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Control word read value |
| ext_mdc | input | 1 | MDC from the external management bus |
| ext_mdio_out | input | 1 | MDIO data from the external bus |
| ext_mdio_oe | input | 1 | MDIO drive enable from the external bus |
| ext_mdio_in | output | 1 | MDIO line value returned to the external bus |
| phy_mdc | output | 1 | MDC toward the PHYs |
| phy_mdio_out | output | 1 | MDIO data toward the PHYs |
| phy_mdio_oe | output | 1 | MDIO drive enable toward the PHYs |
| phy_mdio_in | input | 1 | Resolved MDIO line value |

## Verification
An accepted start write shows busy on the very next cycle. From that edge, t cycles later, MDC equals floor(t/DIV_HALF) mod 2 and the bit on the line is number floor(t/(2*DIV_HALF)). Busy falls, and read data lands in bits 15:0, exactly 2*DIV_HALF times the frame length later. The path mux and the register read-back are combinational and take effect in the same cycle. The bench keeps a behavioural model that advances on every rising edge from the same accepted writes. At every falling edge it compares busy, MDC, drive enable, driven bit, the whole control word and ext_mdio_in. The sampled values have therefore had half a cycle to settle. Directed checks then measure the busy length of each frame and read back the stored data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 64;
  localparam int PRE_W    = 32;
  localparam int TA_POS   = 46;
  localparam int DATA_POS = 48;
  localparam int POS_W    = $clog2(FRAME_W);

  typedef struct packed {
    logic        busy;
    logic        en;
    logic [1:0]  rsv;
    logic        rd;
    logic        sup;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
  } ctrl_t;

  // Full 64-bit frame image, bit 63 leaves first.
  function automatic logic [FRAME_W-1:0] frame_word(input logic rd, input logic [4:0] phy,
                                                    input logic [4:0] ra, input logic [15:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {{PRE_W{1'b1}}, 2'b01, op, phy, ra, ta, rd ? 16'hFFFF : d};
  endfunction

  function automatic logic [POS_W-1:0] first_pos(input logic sup);
    return sup ? POS_W'(PRE_W) : '0;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd,
  input  logic             sup,
  input  logic [4:0]       phy,
  input  logic [4:0]       ra,
  input  logic [15:0]      wdata,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_in,
  output logic             busy,
  output logic             done,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic [15:0]      rdata,
  output logic [POS_W-1:0] bit_pos
);
  logic [FRAME_W-1:0] frame_q;
  logic [POS_W-1:0]   pos_q;
  logic               rd_q;
  logic [15:0]        shift_q;
  logic               last_bit;

  assign last_bit = (pos_q == POS_W'(FRAME_W - 1));
  assign done     = busy && fall_tick && last_bit;
  assign mdio_out = busy ? frame_q[~pos_q] : 1'b0;
  assign mdio_oe  = busy && (!rd_q || (pos_q < POS_W'(TA_POS)));
  assign rdata    = shift_q;
  assign bit_pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pos_q   <= '0;
      rd_q    <= 1'b0;
      frame_q <= '0;
      shift_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        pos_q   <= first_pos(sup);
        rd_q    <= rd;
        frame_q <= frame_word(rd, phy, ra, wdata);
      end
    end else begin
      if (rise_tick && rd_q && (pos_q >= POS_W'(DATA_POS)))
        shift_q <= {shift_q[14:0], mdio_in};
      if (fall_tick) begin
        if (last_bit) busy <= 1'b0;
        else          pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_path_mux.sv
module mdio_path_mux (
  input  logic sel_int,
  input  logic int_mdc,
  input  logic int_out,
  input  logic int_oe,
  input  logic ext_mdc,
  input  logic ext_out,
  input  logic ext_oe,
  input  logic pin_in,
  output logic phy_mdc,
  output logic phy_out,
  output logic phy_oe,
  output logic ext_in
);
  always_comb begin
    if (sel_int) begin
      phy_mdc = int_mdc;
      phy_out = int_out;
      phy_oe  = int_oe;
      ext_in  = 1'b1;
    end else begin
      phy_mdc = ext_mdc;
      phy_out = ext_out;
      phy_oe  = ext_oe;
      ext_in  = pin_in;
    end
  end
endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ext_mdc,
  input  logic        ext_mdio_out,
  input  logic        ext_mdio_oe,
  output logic        ext_mdio_in,
  output logic        phy_mdc,
  output logic        phy_mdio_out,
  output logic        phy_mdio_oe,
  input  logic        phy_mdio_in
);
  ctrl_t             wr_word;
  ctrl_t             rd_word;
  logic              en_q;
  logic [1:0]        rsv_q;
  logic              rd_q;
  logic              sup_q;
  logic [4:0]        phy_q;
  logic [4:0]        ra_q;
  logic [15:0]       data_q;

  logic              busy;
  logic              accept;
  logic              start;
  logic              done;
  logic              seq_mdc;
  logic              seq_out;
  logic              seq_oe;
  logic              rise_tick;
  logic              fall_tick;
  logic [15:0]       seq_rdata;
  logic [POS_W-1:0]  bit_pos;

  assign wr_word = ctrl_t'(reg_wdata);
  assign accept  = reg_wr && !busy;
  assign start   = accept && wr_word.busy && wr_word.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      rsv_q  <= '0;
      rd_q   <= 1'b0;
      sup_q  <= 1'b0;
      phy_q  <= '0;
      ra_q   <= '0;
      data_q <= '0;
    end else if (accept) begin
      en_q   <= wr_word.en;
      rsv_q  <= wr_word.rsv;
      rd_q   <= wr_word.rd;
      sup_q  <= wr_word.sup;
      phy_q  <= wr_word.phy;
      ra_q   <= wr_word.ra;
      data_q <= wr_word.data;
    end else if (done && rd_q) begin
      data_q <= seq_rdata;
    end
  end

  always_comb begin
    rd_word.busy = busy;
    rd_word.en   = en_q;
    rd_word.rsv  = rsv_q;
    rd_word.rd   = rd_q;
    rd_word.sup  = sup_q;
    rd_word.phy  = phy_q;
    rd_word.ra   = ra_q;
    rd_word.data = data_q;
  end
  assign reg_rdata = rd_word;

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(seq_mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .rd(wr_word.rd), .sup(wr_word.sup), .phy(wr_word.phy), .ra(wr_word.ra),
    .wdata(wr_word.data), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_in(phy_mdio_in), .busy(busy), .done(done),
    .mdio_out(seq_out), .mdio_oe(seq_oe), .rdata(seq_rdata), .bit_pos(bit_pos)
  );

  mdio_path_mux u_mux (
    .sel_int(en_q), .int_mdc(seq_mdc), .int_out(seq_out), .int_oe(seq_oe),
    .ext_mdc(ext_mdc), .ext_out(ext_mdio_out), .ext_oe(ext_mdio_oe),
    .pin_in(phy_mdio_in), .phy_mdc(phy_mdc), .phy_out(phy_mdio_out),
    .phy_oe(phy_mdio_oe), .ext_in(ext_mdio_in)
  );
endmodule

// File: rtl/mdio_ctl_master_chk.sv
module mdio_ctl_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        wr_go,
  input logic        wr_en,
  input logic [14:0] fields,
  input logic        busy,
  input logic        en,
  input logic        rd,
  input logic        seq_mdc,
  input logic        seq_oe,
  input logic [5:0]  bit_pos,
  input logic        rise_tick,
  input logic        fall_tick
);
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr && wr_go && wr_en) |=> busy);

  p_no_start_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr && !wr_en) |=> !busy);

  p_busy_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> en);

  p_hold_fields_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr) |=> $stable(fields));

  p_idle_mdc_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !seq_mdc);

  p_rise_r5: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> seq_mdc);

  p_fall_r5: assert property (@(posedge clk) disable iff (rst)
    fall_tick |=> !seq_mdc);

  p_idle_release_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !seq_oe);

  p_write_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd) |-> seq_oe);

  p_read_release_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && rd && bit_pos >= 6'd46) |-> !seq_oe);
endmodule

bind mdio_ctl_master mdio_ctl_master_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .wr_go(reg_wdata[31]), .wr_en(reg_wdata[30]),
  .fields(reg_rdata[30:16]), .busy(busy), .en(en_q), .rd(rd_q),
  .seq_mdc(seq_mdc), .seq_oe(seq_oe), .bit_pos(bit_pos),
  .rise_tick(rise_tick), .fall_tick(fall_tick)
);

// File: tb/mdio_ctl_master_tb.sv
module mdio_ctl_master_tb;
  localparam int DH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ext_mdc = 1'b0, ext_mdio_out = 1'b0, ext_mdio_oe = 1'b0;
  logic ext_mdio_in, phy_mdc, phy_mdio_out, phy_mdio_oe, phy_mdio_in;

  always #4 clk = ~clk;

  mdio_ctl_master #(.DIV_HALF(DH)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_mdc(ext_mdc), .ext_mdio_out(ext_mdio_out), .ext_mdio_oe(ext_mdio_oe),
    .ext_mdio_in(ext_mdio_in), .phy_mdc(phy_mdc), .phy_mdio_out(phy_mdio_out),
    .phy_mdio_oe(phy_mdio_oe), .phy_mdio_in(phy_mdio_in)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_active = 1'b0;
  int          m_t = 0, m_first = 0, m_n = 64;
  logic [63:0] m_frame = '0;
  logic [31:0] m_word = '0;   // stored fields, busy bit kept 0
  bit          resp_present = 1'b0;
  logic [15:0] resp_data = '0;
  int          m_pos;
  logic        resp_val;

  assign m_pos    = m_first + m_t / (2 * DH);
  assign resp_val = (m_active && m_word[27] && resp_present && m_pos >= 48) ? resp_data[63 - m_pos] : 1'b1;
  assign phy_mdio_in = phy_mdio_oe ? phy_mdio_out : resp_val;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_active = 1'b0; m_t = 0; m_word = '0;
    end else if (m_active) begin
      m_t++;
      if (m_t == 2 * DH * m_n) begin
        m_active = 1'b0;
        if (m_word[27]) m_word[15:0] = resp_present ? resp_data : 16'hFFFF;
      end
    end else if (reg_wr) begin
      m_word = {1'b0, reg_wdata[30:0]};
      if (reg_wdata[31] && reg_wdata[30]) begin
        m_active = 1'b1; m_t = 0;
        m_first  = reg_wdata[26] ? 32 : 0;
        m_n      = 64 - m_first;
        m_frame  = {32'hFFFF_FFFF, 2'b01, reg_wdata[27] ? 2'b10 : 2'b01,
                    reg_wdata[25:21], reg_wdata[20:16], 2'b10, reg_wdata[15:0]};
      end
    end
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      logic e_mdc, e_oe;
      chk(m_active && m_first == 32 ? "R8 busy" : "R4 busy", {31'b0, reg_rdata[31]}, {31'b0, m_active});
      chk("R9 control word", {1'b0, reg_rdata[30:0]}, m_word);
      if (m_active) begin
        e_mdc = ((m_t / DH) % 2) == 1;
        e_oe  = !m_word[27] || m_pos < 46;
        chk("R5 mdc", {31'b0, phy_mdc}, {31'b0, e_mdc});
        chk(m_word[27] ? "R7 oe" : "R6 oe", {31'b0, phy_mdio_oe}, {31'b0, e_oe});
        if (e_oe) chk(m_word[27] ? "R7 bit" : "R6 bit", {31'b0, phy_mdio_out}, {31'b0, m_frame[63 - m_pos]});
      end else if (m_word[30]) begin
        chk("R3 idle mdc", {31'b0, phy_mdc}, 32'd0);
        chk("R3 idle oe", {31'b0, phy_mdio_oe}, 32'd0);
      end else begin
        chk("R2 mdc", {31'b0, phy_mdc}, {31'b0, ext_mdc});
        chk("R2 oe", {31'b0, phy_mdio_oe}, {31'b0, ext_mdio_oe});
        chk("R2 out", {31'b0, phy_mdio_out}, {31'b0, ext_mdio_out});
      end
      chk(m_word[30] ? "R3 ext_in" : "R2 ext_in", {31'b0, ext_mdio_in},
          {31'b0, m_word[30] ? 1'b1 : phy_mdio_in});
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (reg_rdata[31]) begin n++; @(negedge clk); end
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'd0);
    chk("R1 reset oe", {31'b0, phy_mdio_oe}, 32'd0);
    chk("R1 reset mdc", {31'b0, phy_mdc}, 32'd0);
    rst = 1'b0; cmp_on = 1'b1;

    // R2 pass-through
    ext_mdc = 1'b1; ext_mdio_out = 1'b0; ext_mdio_oe = 1'b1;
    @(negedge clk);
    chk("R2 pass mdc", {31'b0, phy_mdc}, 32'd1);
    chk("R2 ext_in", {31'b0, ext_mdio_in}, 32'd0);
    ext_mdio_oe = 1'b0; ext_mdc = 1'b0;
    @(negedge clk);

    // R11 busy bit without enable
    wr(32'h8000_1234);
    repeat (4) @(negedge clk);
    chk("R11 no start", reg_rdata, 32'h0000_1234);

    // R3 enable only: external pins cut off
    wr(32'h4000_0000);
    ext_mdc = 1'b1; ext_mdio_oe = 1'b1; ext_mdio_out = 1'b0;
    @(negedge clk);
    chk("R3 mdc held", {31'b0, phy_mdc}, 32'd0);
    chk("R3 ext_in", {31'b0, ext_mdio_in}, 32'd1);
    ext_mdc = 1'b0; ext_mdio_oe = 1'b0;

    // R6 write frame with preamble, R9 write during frame
    wr(32'hC0BA_A5C3);
    repeat (100) @(negedge clk);
    wr(32'hC87F_0000);
    wait_idle(n);
    chk("R9 ignored", reg_rdata, 32'h40BA_A5C3);

    // R7/R8 read with suppressed preamble
    resp_present = 1'b1; resp_data = 16'h3C96;
    wr(32'hCC22_0000);
    wait_idle(n);
    chk("R8 busy length", n, 2 * DH * 32);
    chk("R7 read data", reg_rdata, 32'h4C22_3C96);

    // R10 read with no PHY, full preamble
    resp_present = 1'b0;
    wr(32'hC83F_0000);
    wait_idle(n);
    chk("R4 busy length", n, 2 * DH * 64);
    chk("R10 no phy", {16'b0, reg_rdata[15:0]}, 32'h0000_FFFF);

    // R8 write with suppressed preamble
    wr(32'hC4E0_8001);
    wait_idle(n);
    chk("R8 write length", n, 2 * DH * 32);

    // R2 back to pass-through
    wr(32'h0000_0000);
    ext_mdc = 1'b1;
    @(negedge clk);
    chk("R2 restore", {31'b0, phy_mdc}, 32'd1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule